// File: doc/BRIEF.md
# Sixteen-Operation Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two W-bit operands, a carry input bit and a 4-bit operation code, and returns a W-bit result together with a carry output. The top bit of the operation code picks one of two halves. When it is 0, the result comes from a bitwise unit that can pass either operand, complement either operand, or form AND, NAND, OR or NOR. When it is 1, the result comes from a single shared adder.

The arithmetic half never uses a separate subtractor or incrementer. Each adder input is conditioned first: it can take its operand unchanged, take the two's-complement negation of the operand, or take zero. The adder's carry input is also selected, from constant 0, constant 1 or the external carry bit. A small decoder turns the operation code into these three selects. This gives increments, addition, subtraction in both directions, the negated sum, add-plus-one and add-with-carry.

Top module: `opsel_alu`

## Requirements
- R1: With op[3]=0, y is set by op[2:0]: 000 gives a, 001 gives ~a, 010 gives b, 011 gives ~b, 100 gives a&b, 101 gives ~(a&b), 110 gives a|b, 111 gives ~(a|b).
- R2: With op[3]=1, y is the arithmetic result modulo 2^W, selected by op[2:0]: 000 gives a+1, 001 gives b+1, 010 gives a+b, 011 gives a-b, 100 gives -a+b, 101 gives -a-b, 110 gives a+b+1, 111 gives a+b+cin.
- R3: The cin input affects y and cout only for op=1111. For every other code, both outputs are the same whatever cin is.
- R4: For op[3]=1, cout is bit W of the (W+1)-bit sum X+Y+C. Here X and Y are the conditioned adder inputs (operand, (2^W-operand) mod 2^W, or 0) and C is the selected carry. For op[3]=0, cout is 0.
- R5: The increments are built as operand + 0 with carry 1. So for op=1000 with a all ones (and op=1001 with b all ones), y is 0 and cout is 1.
- R6: Negating a zero operand gives a zero adder input. So op=1100 with a=0 gives y=b and cout=0, and op=1101 with a=b=0 gives y=0 and cout=0.
- R7: The result is taken from the bitwise unit exactly when op[3]=0, and from the adder exactly when op[3]=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | External carry, used only by code 1111 |
| op | input | 4 | Operation code; bit 3 selects the arithmetic half |
| y | output | W | Result |
| cout | output | 1 | Adder carry output, 0 for bitwise codes |

## Verification
The assertions are evaluated combinationally. They assume the four inputs hold steady while the result settles and that they carry only known 0/1 values, so no opcode ever decodes to an undefined select. The stimulus changes the inputs once per clock, shortly after the rising edge, and always drives full known values, including all-ones and zero operands. Results are compared only at the falling edge, after the inputs have settled.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  // Adder input conditioning choices
  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_NEG  = 2'd1,
    SRC_ZERO = 2'd2
  } src_sel_e;

  // Adder carry-in choices
  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_EXT  = 2'd2
  } ci_sel_e;

  typedef struct packed {
    src_sel_e x_sel;
    src_sel_e y_sel;
    ci_sel_e  c_sel;
  } adder_ctl_t;

  // Opcode to adder setup; the bitwise half leaves the adder idle
  function automatic adder_ctl_t decode_op(input logic [3:0] op);
    adder_ctl_t c;
    c = '{x_sel: SRC_ZERO, y_sel: SRC_ZERO, c_sel: CI_ZERO};
    if (op[3]) begin
      case (op[2:0])
        3'd0:    c = '{x_sel: SRC_PASS, y_sel: SRC_ZERO, c_sel: CI_ONE};
        3'd1:    c = '{x_sel: SRC_ZERO, y_sel: SRC_PASS, c_sel: CI_ONE};
        3'd2:    c = '{x_sel: SRC_PASS, y_sel: SRC_PASS, c_sel: CI_ZERO};
        3'd3:    c = '{x_sel: SRC_PASS, y_sel: SRC_NEG,  c_sel: CI_ZERO};
        3'd4:    c = '{x_sel: SRC_NEG,  y_sel: SRC_PASS, c_sel: CI_ZERO};
        3'd5:    c = '{x_sel: SRC_NEG,  y_sel: SRC_NEG,  c_sel: CI_ZERO};
        3'd6:    c = '{x_sel: SRC_PASS, y_sel: SRC_PASS, c_sel: CI_ONE};
        default: c = '{x_sel: SRC_PASS, y_sel: SRC_PASS, c_sel: CI_EXT};
      endcase
    end
    return c;
  endfunction

  // One-bit full adder pieces: odd parity and majority
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import opsel_alu_pkg::*;
(
  input  logic [3:0] op,
  input  logic       cin,
  output src_sel_e   x_sel,
  output src_sel_e   y_sel,
  output ci_sel_e    c_sel,
  output logic       carry_in,
  output logic       use_arith
);
  adder_ctl_t ctl;

  always_comb begin
    ctl   = decode_op(op);
    x_sel = ctl.x_sel;
    y_sel = ctl.y_sel;
    c_sel = ctl.c_sel;
    case (ctl.c_sel)
      CI_ONE:  carry_in = 1'b1;
      CI_EXT:  carry_in = cin;
      default: carry_in = 1'b0;
    endcase
  end

  assign use_arith = op[3];
endmodule

// File: rtl/alu_operand_cond.sv
module alu_operand_cond
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] v,
  input  src_sel_e     sel,
  output logic [W-1:0] out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    case (sel)
      SRC_PASS: out = v;
      SRC_NEG:  out = ~v + ONE;
      default:  out = '0;
    endcase
  end
endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
  parameter int W = 8
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  always_comb begin
    case (fn)
      3'd0:    r = a;
      3'd1:    r = ~a;
      3'd2:    r = b;
      3'd3:    r = ~b;
      3'd4:    r = a & b;
      3'd5:    r = ~(a & b);
      3'd6:    r = a | b;
      default: r = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_shared_adder.sv
module alu_shared_adder
  import opsel_alu_pkg::*;
#(
  parameter int W      = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  generate
    if (RIPPLE) begin : g_ripple
      always_comb begin
        logic c;
        c = ci;
        for (int i = 0; i < W; i++) begin
          s[i] = fa_sum(x[i], y[i], c);
          c    = fa_carry(x[i], y[i], c);
        end
        co = c;
      end
    end else begin : g_infer
      logic [W:0] full;
      assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      assign s    = full[W-1:0];
      assign co   = full[W];
    end
  endgenerate
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W      = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [3:0]   op,
  output logic [W-1:0] y,
  output logic         cout
);
  src_sel_e     x_sel, y_sel;
  ci_sel_e      c_sel;
  logic         carry_in;
  logic         use_arith;
  logic [W-1:0] add_x, add_y;
  logic [W-1:0] sum_y;
  logic         sum_co;
  logic [W-1:0] logic_y;

  alu_ctrl_decode u_dec (
    .op(op), .cin(cin), .x_sel(x_sel), .y_sel(y_sel),
    .c_sel(c_sel), .carry_in(carry_in), .use_arith(use_arith)
  );

  alu_operand_cond #(.W(W)) u_cond_x (.v(a), .sel(x_sel), .out(add_x));
  alu_operand_cond #(.W(W)) u_cond_y (.v(b), .sel(y_sel), .out(add_y));

  alu_shared_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
    .x(add_x), .y(add_y), .ci(carry_in), .s(sum_y), .co(sum_co)
  );

  alu_bitwise_unit #(.W(W)) u_bit (.fn(op[2:0]), .a(a), .b(b), .r(logic_y));

  assign y    = use_arith ? sum_y : logic_y;
  assign cout = use_arith & sum_co;
endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic [W-1:0] y,
  input logic         cout,
  input logic [W-1:0] logic_y,
  input logic [W-1:0] sum_y,
  input ci_sel_e      c_sel,
  input src_sel_e     x_sel
);
  always_comb begin
    if (!op[3]) begin
      assert_bitwise_path_R7: assert (y == logic_y)
        else $error("bitwise half not routed");
      assert_cout_quiet_R4: assert (cout == 1'b0)
        else $error("carry out active on bitwise code");
    end else begin
      assert_adder_path_R2: assert (y == sum_y)
        else $error("adder half not routed");
    end
    if (op != 4'hF) begin
      assert_cin_unused_R3: assert (c_sel != CI_EXT)
        else $error("external carry selected on wrong code");
    end
    if (op == 4'h8) begin
      assert_inc_wrap_R5: assert (cout == (&a) && y == a + 1'b1)
        else $error("increment of a wrong");
    end
    if (op == 4'hB && a == b) begin
      assert_self_sub_R2: assert (y == '0)
        else $error("a-a not zero");
    end
    if (op == 4'hC && a == '0) begin
      assert_neg_zero_R6: assert (x_sel == SRC_NEG && y == b && cout == 1'b0)
        else $error("negated zero not zero");
    end
  end
endmodule

bind opsel_alu opsel_alu_chk #(.W(W)) u_chk (
  .a(a), .b(b), .op(op), .y(y), .cout(cout),
  .logic_y(logic_y), .sum_y(sum_y), .c_sel(c_sel), .x_sel(x_sel)
);

// File: tb/opsel_alu_tb.sv
module opsel_alu_tb;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4ns clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] y;
  logic         cout;

  opsel_alu u_dut (.a(a), .b(b), .cin(cin), .op(op), .y(y), .cout(cout));

  typedef struct {
    logic [3:0]   op;
    logic [W-1:0] ey;
    logic         eco;
    string        tag;
  } item_t;

  item_t q[$];
  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;

  // Requirement-level model: returns {carry, result}
  function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] va,
                                       input logic [W-1:0] vb, input logic c);
    logic [W-1:0] na, nb;
    na = '0 - va;
    nb = '0 - vb;
    case (o)
      4'h0: return {1'b0, va};
      4'h1: return {1'b0, ~va};
      4'h2: return {1'b0, vb};
      4'h3: return {1'b0, ~vb};
      4'h4: return {1'b0, va & vb};
      4'h5: return {1'b0, ~(va & vb)};
      4'h6: return {1'b0, va | vb};
      4'h7: return {1'b0, ~(va | vb)};
      4'h8: return {1'b0, va} + 1;
      4'h9: return {1'b0, vb} + 1;
      4'hA: return {1'b0, va} + {1'b0, vb};
      4'hB: return {1'b0, va} + {1'b0, nb};
      4'hC: return {1'b0, na} + {1'b0, vb};
      4'hD: return {1'b0, na} + {1'b0, nb};
      4'hE: return {1'b0, va} + {1'b0, vb} + 1;
      default: return {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, c};
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [W-1:0] va,
                       input logic [W-1:0] vb, input logic c, input string tag);
    item_t it;
    logic [W:0] r;
    @(posedge clk);
    #1ns;
    op = o; a = va; b = vb; cin = c;
    r = model(o, va, vb, c);
    it.op = o; it.ey = r[W-1:0]; it.eco = r[W]; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drive_exp(input logic [3:0] o, input logic [W-1:0] va,
                           input logic [W-1:0] vb, input logic c,
                           input logic [W-1:0] ey, input logic eco, input string tag);
    item_t it;
    @(posedge clk);
    #1ns;
    op = o; a = va; b = vb; cin = c;
    it.op = o; it.ey = ey; it.eco = eco; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (y !== it.ey || cout !== it.eco) begin
          errors++;
          $display("FAIL %s op=%h: actual y=%h cout=%b expected y=%h cout=%b",
                   it.tag, it.op, y, cout, it.ey, it.eco);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // R1 idle state: all inputs zero
    drive_exp(4'h0, '0, '0, 1'b0, '0, 1'b0, "R1 idle");
    // R1 each bitwise code with a distinct pattern
    for (int o = 0; o < 8; o++) drive(o[3:0], 8'hC5, 8'h3A, 1'b0, "R1");
    for (int o = 0; o < 8; o++) drive(o[3:0], 8'hF0, 8'hAA, 1'b1, "R1");
    // R2 arithmetic codes with hand-checked values
    drive_exp(4'hA, 8'd100, 8'd27, 1'b0, 8'd127, 1'b0, "R2 add");
    drive_exp(4'hB, 8'd5, 8'd9, 1'b0, 8'hFC, 1'b0, "R2 a-b");
    drive_exp(4'hC, 8'd5, 8'd9, 1'b0, 8'd4, 1'b1, "R2 -a+b");
    drive_exp(4'hD, 8'd1, 8'd2, 1'b0, 8'hFD, 1'b1, "R2 -a-b");
    drive_exp(4'hE, 8'd10, 8'd20, 1'b0, 8'd31, 1'b0, "R2 a+b+1");
    drive_exp(4'hF, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, "R2 a+b+cin");
    drive_exp(4'hF, 8'hFF, 8'h00, 1'b0, 8'hFF, 1'b0, "R2 a+b+cin");
    // R4 carry out: add overflow, and a-b with b=0 leaves no carry
    drive_exp(4'hA, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, "R4 add carry");
    drive_exp(4'hB, 8'h07, 8'h00, 1'b0, 8'h07, 1'b0, "R4 sub by zero");
    drive_exp(4'h7, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, "R4 bitwise quiet");
    // R5 increments wrapping
    drive_exp(4'h8, ONES, 8'h55, 1'b0, 8'h00, 1'b1, "R5 inc a");
    drive_exp(4'h9, 8'h55, ONES, 1'b1, 8'h00, 1'b1, "R5 inc b");
    drive_exp(4'h8, 8'h41, 8'h00, 1'b0, 8'h42, 1'b0, "R5 inc a");
    // R6 negating zero
    drive_exp(4'hC, 8'h00, 8'h9E, 1'b0, 8'h9E, 1'b0, "R6 -0+b");
    drive_exp(4'hD, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, "R6 -0-0");
    // R3 cin has no effect except on 1111
    for (int o = 0; o < 15; o++) begin
      drive(o[3:0], 8'h6B, 8'hD4, 1'b0, "R3 cin=0");
      drive(o[3:0], 8'h6B, 8'hD4, 1'b1, "R3 cin=1");
    end
    // R7 / R1 / R2 random sweep over all codes
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ro;
      ro = 4'(n % 16);
      drive(ro, W'($urandom), W'($urandom), 1'($urandom),
            ro[3] ? "R7 R2 random" : "R7 R1 random");
    end
    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule